// File: doc/BRIEF.md
# Per-Source Trigger Interrupt Controller

The block gathers 32 asynchronous interrupt lines and turns them into two processor requests: a normal request and a fast request. Software sets up each line through bit-mapped configuration words. One word picks edge or level detection, one picks the active polarity, one masks the line, and one steers it to the fast output. Edge events are held in a per-line latch. The latch stays set until software writes a one to that line's bit in a clear command word.

Software reads three views. The first is the raw status of every line. The second is the masked pending set. The third is a service word that gives the index of the lowest-numbered pending line and a valid flag. The register port is a plain single-cycle write strobe with a combinational read mux. Writes land on the next clock edge.

Top module: `irqc_top`

## Requirements
- R1: Each line passes through two synchronising flops. A level-mode line shows up in the raw status (word 5) two clock edges after it is sampled.
- R2: A 1 in the mode word (word 0) gives a line edge detection. A 0 gives level detection, and in level mode the raw status follows the polarity-adjusted input with no latching.
- R3: A 0 in the polarity word (word 1) means active-high or rising edge. A 1 means active-low or falling edge.
- R4: An edge-mode line's event is latched one edge after it is seen on the synchronised input. The latch stays set after the input returns to idle.
- R5: Writing word 4 clears the latch of each line whose data bit is 1 and leaves the other lines untouched. A new event in the same cycle wins over the clear. Word 4 reads as zero.
- R6: A 1 in the mask word (word 2) disables a line. The pending word (word 6) equals raw status AND NOT mask.
- R7: `irq_o` is the OR of pending lines whose bit in the fast-select word (word 3) is 0. `fiq_o` is the OR of pending lines whose fast-select bit is 1.
- R8: The service index is the lowest-numbered pending line, and its valid flag is set only when some line is pending. In word 7 the index sits in bits 4:0 and the valid flag in bit 31, with all other bits zero.
- R9: After reset the mode, polarity and fast-select words are all zeros and the mask word is all ones. Both request outputs are low.
- R10: Writes to the read-only words 5, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous interrupt lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected word (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| next_idx_o | output | 5 | Lowest pending line index |
| next_vld_o | output | 1 | Some line is pending |

## Verification
A change on a level line reaches the raw status, the requests and the service word after the second clock edge. An edge line reaches them after the third edge, because its latch sits one flop past the synchroniser. Configuration and clear writes take effect from the edge that captures them. Read data is combinational on the selected word. The bench's behavioural model advances on the same edges and computes these delays from the requirements. Inputs change just after a rising edge, and every output is compared at the following falling edge, so each result is checked in the exact cycle it becomes due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    SEL_MODE  = 3'd0,
    SEL_POL   = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_FAST  = 3'd3,
    SEL_CLR   = 3'd4,
    SEL_RAW   = 3'd5,
    SEL_PEND  = 3'd6,
    SEL_NEXT  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] mode_i,   // 1 = edge
  input  logic [W-1:0] pol_i,    // 1 = low / falling
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] dly_q, latch_q, act, act_d, evt;

  // polarity applied to both samples so a polarity change makes no edge
  assign act   = sync_i ^ pol_i;
  assign act_d = dly_q ^ pol_i;
  assign evt   = mode_i & act & ~act_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q   <= '0;
      latch_q <= '0;
    end else begin
      dly_q   <= sync_i;
      latch_q <= (latch_q & ~clr_i) | evt;
    end
  end

  assign raw_o = (mode_i & latch_q) | (~mode_i & act);

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(latch_q) & ~$past(clr_i)) & ~latch_q) == '0)); // R4
  AST_CLR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(clr_i) & ~$past(evt)) & latch_q) == '0)); // R5
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        vld_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (vld_o) begin
      AST_NEXT_IS_SET: assert (req_i[idx_o]); // R8
      AST_NEXT_LOWEST: assert ((req_i & ((W'(1) << idx_o) - W'(1))) == '0); // R8
    end else begin
      AST_NONE_EMPTY: assert (req_i == '0); // R8
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [N_SRC-1:0] reg_wdata_i,
  output logic [N_SRC-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             fiq_o,
  output logic [IDX_W-1:0] next_idx_o,
  output logic             next_vld_o
);
  logic [N_SRC-1:0] mode_q, pol_q, mask_q, fast_q;
  logic [N_SRC-1:0] sync_w, raw_w, pend_w, clr_w;
  reg_sel_e         sel;

  assign sel   = reg_sel_e'(reg_addr_i);
  assign clr_w = (reg_we_i && sel == SEL_CLR) ? reg_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      pol_q  <= '0;
      mask_q <= '1;
      fast_q <= '0;
    end else if (reg_we_i) begin
      case (sel)
        SEL_MODE: mode_q <= reg_wdata_i;
        SEL_POL:  pol_q  <= reg_wdata_i;
        SEL_MASK: mask_q <= reg_wdata_i;
        SEL_FAST: fast_q <= reg_wdata_i;
        default:  ;
      endcase
    end
  end

  irqc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (sync_w)
  );

  irqc_detect #(.W(N_SRC)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_w),
    .mode_i(mode_q),
    .pol_i (pol_q),
    .clr_i (clr_w),
    .raw_o (raw_w)
  );

  assign pend_w = raw_w & ~mask_q;

  irqc_prio #(.W(N_SRC), .IDX_W(IDX_W)) u_prio (
    .req_i(pend_w),
    .idx_o(next_idx_o),
    .vld_o(next_vld_o)
  );

  assign irq_o = |(pend_w & ~fast_q);
  assign fiq_o = |(pend_w & fast_q);

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      SEL_MODE: reg_rdata_o = mode_q;
      SEL_POL:  reg_rdata_o = pol_q;
      SEL_MASK: reg_rdata_o = mask_q;
      SEL_FAST: reg_rdata_o = fast_q;
      SEL_RAW:  reg_rdata_o = raw_w;
      SEL_PEND: reg_rdata_o = pend_w;
      SEL_NEXT: begin
        reg_rdata_o[IDX_W-1:0] = next_idx_o;
        reg_rdata_o[N_SRC-1]   = next_vld_o;
      end
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_MASKED_NOT_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_vld_o |-> !mask_q[next_idx_o]); // R6
  AST_QUIET_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !next_vld_o |-> (!irq_o && !fiq_o)); // R7
  AST_RO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i >= 3'd5) |=> ($stable(mode_q) && $stable(mask_q) && $stable(fast_q) && $stable(pol_q))); // R10
endmodule

// File: tb/irqc_top_test.sv
`timescale 1ns/100ps
module irqc_top_test;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          we = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq, fiq, nvld;
  logic [4:0]    nidx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R9";

  irqc_top uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq),
    .next_idx_o(nidx), .next_vld_o(nvld)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  logic [N-1:0] m_s1, m_s2, m_d, m_mode, m_pol, m_mask, m_fast, m_latch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_d = '0; m_latch = '0;
      m_mode = '0; m_pol = '0; m_mask = '1; m_fast = '0;
    end else begin
      logic [N-1:0] ev, clr;
      ev  = m_mode & (m_s2 ^ m_pol) & ~(m_d ^ m_pol);
      clr = (we && addr == 3'd4) ? wdata : '0;
      m_latch = (m_latch & ~clr) | ev;
      if (we) begin
        case (addr)
          3'd0: m_mode = wdata;
          3'd1: m_pol  = wdata;
          3'd2: m_mask = wdata;
          3'd3: m_fast = wdata;
          default: ;
        endcase
      end
      m_d = m_s2; m_s2 = m_s1; m_s1 = src;
    end
  end

  function automatic logic [N-1:0] m_raw();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = m_mode[i] ? m_latch[i] : (m_s2[i] ^ m_pol[i]);
    return r;
  endfunction

  function automatic int m_next();
    logic [N-1:0] p;
    p = m_raw() & ~m_mask;
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [N-1:0] m_read(input logic [2:0] a);
    logic [N-1:0] r;
    int nx;
    r = '0;
    nx = m_next();
    case (a)
      3'd0: r = m_mode;
      3'd1: r = m_pol;
      3'd2: r = m_mask;
      3'd3: r = m_fast;
      3'd5: r = m_raw();
      3'd6: r = m_raw() & ~m_mask;
      3'd7: if (nx >= 0) begin r[4:0] = nx[4:0]; r[N-1] = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] p;
      int nx;
      p  = m_raw() & ~m_mask;
      nx = m_next();
      chk(cur_tag, "rdata", rdata, m_read(addr));
      chk("R7", "irq", N'(irq), N'(|(p & ~m_fast)));
      chk("R7", "fiq", N'(fiq), N'(|(p & m_fast)));
      chk("R8", "vld", N'(nvld), N'(nx >= 0));
      if (nx >= 0) chk("R8", "idx", N'(nidx), N'(nx));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    addr = a;
  endtask

  initial begin
    tick(3);
    // R9: reset values checked directly
    #1;
    addr = 3'd2; #0.5; chk("R9", "mask reset", rdata, '1);
    addr = 3'd0; #0.5; chk("R9", "mode reset", rdata, '0);
    addr = 3'd3; #0.5; chk("R9", "fast reset", rdata, '0);
    chk("R9", "irq reset", N'(irq), '0);
    rst_n = 1'b1;
    tick(2);

    cur_tag = "R1";
    wr(3'd2, '0);
    rd(3'd5);
    src[3] = 1'b1; tick(4);
    src[3] = 1'b0; tick(4);

    cur_tag = "R3";
    wr(3'd1, 32'h0000_0020);
    tick(3);
    src[5] = 1'b1; tick(4);
    src[5] = 1'b0; tick(3);
    wr(3'd1, '0);

    cur_tag = "R2";
    wr(3'd0, 32'h0000_0100);
    src[8] = 1'b1; tick(1); src[8] = 1'b0;
    tick(5);

    cur_tag = "R4";
    rd(3'd6);
    tick(6);

    cur_tag = "R5";
    wr(3'd4, 32'h0000_0001);
    tick(2);
    wr(3'd4, 32'h0000_0100);
    rd(3'd4); tick(2);
    rd(3'd5);
    wr(3'd0, 32'h0000_0300);
    wr(3'd1, 32'h0000_0200);
    src[9] = 1'b1; tick(4);
    src[9] = 1'b0; tick(4);
    src[8] = 1'b1; tick(2);
    wr(3'd4, 32'h0000_0100);
    tick(3);
    wr(3'd4, 32'hffff_ffff);
    tick(2);

    cur_tag = "R6";
    wr(3'd0, '0); wr(3'd1, '0);
    src = 32'h0010_0410;
    rd(3'd6); tick(3);
    wr(3'd2, 32'h0000_0010);
    tick(2);

    cur_tag = "R7";
    wr(3'd3, 32'h0000_0400);
    tick(2);
    wr(3'd3, 32'h0010_0410);
    tick(2);

    cur_tag = "R8";
    rd(3'd7);
    wr(3'd2, 32'h0000_0410); tick(2);
    wr(3'd2, '1); tick(2);
    wr(3'd2, '0); src = 32'h8000_0000; tick(4);
    src = '0; tick(4);

    cur_tag = "R10";
    src = 32'h0000_00f0; tick(3);
    wr(3'd5, '0); wr(3'd6, '0); wr(3'd7, 32'h1234_5678);
    rd(3'd6); tick(2);
    rd(3'd2); tick(1);

    cur_tag = "R2";
    for (int k = 0; k < 400; k++) begin
      src = $urandom();
      if (($urandom() % 4) == 0) begin
        logic [2:0] a;
        a = 3'($urandom());
        wr(a, $urandom());
      end else begin
        rd(3'($urandom()));
        tick();
      end
    end
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule